// File: doc/BRIEF.md
# Hot-Plug Detect and Sink Status Controller

This block drives the hot-plug detect line and the downstream sink status of a bridge that turns a digital display link into an analog monitor output. It holds the line low until the chip's start-up sequence finishes. It then follows one of two hot-plug policies, chosen by a static select pin that is sampled once. It also keeps a sink-count register value and a sticky "downstream status changed" flag that the host clears by writing one.

When the select pin reads low, the line goes high as soon as start-up ends, whatever the monitor state. Each later attach or detach of the monitor then updates the sink count and sets the sticky flag. It also sends a short low-going interrupt pulse on the line. Changes that arrive while a pulse, or the quiet time after it, is still running are held back, so pulses never come closer together than a fixed interval. When the select pin reads high, the line simply follows the debounced monitor-present state.

The monitor-present input is asynchronous. It passes through a two-stage synchronizer and must then hold a new level for a set number of cycles before it counts as a change.

Top module: `hpd_sink_ctrl`

## Requirements
- R1: While reset is applied and until `initDone` is first seen high, `hpdLine` is 0. During that time `sinkCount` is 0 and `statusChanged` is 0.
- R2: `monPresent` is synchronized by two flip-flops. A new level counts as a change only after it has held for `STABLE_CYCLES` consecutive cycles. A shorter excursion changes neither `hpdLine`, `sinkCount` nor `statusChanged`.
- R3: `sinkCount` is 1 when the debounced monitor state is present and 0 when it is absent. It is loaded when start-up completes and reloaded on every accepted change, in both policies.
- R4: With `modeSel` = 0 at start-up, `hpdLine` goes to 1 one cycle after `initDone` is seen. This happens even when `sinkCount` is 0.
- R5: With `modeSel` = 0, every accepted change sets `statusChanged` to 1. It stays 1 until a cycle with `statClr` = 1 and no new change. If a clear and a change fall in the same cycle, it stays 1.
- R6: With `modeSel` = 0, an accepted change while the line is idle-high drives `hpdLine` low from the same cycle in which `sinkCount` updates. It stays low for exactly IRQ_CYCLES = CLK_FREQ_HZ*3/4000 cycles (0.75 ms) and then returns to 1.
- R7: With `modeSel` = 0, changes accepted during a pulse or during the GAP_CYCLES = CLK_FREQ_HZ/500 high cycles (2 ms) after it are queued. The next pulse starts exactly GAP_CYCLES after the previous one ends, and any number of queued changes yield one pulse.
- R8: With `modeSel` = 1, `hpdLine` equals the debounced monitor state after start-up. No low pulse is ever produced, and `statusChanged` is never set.
- R9: `modeSel` is sampled only in the cycle where start-up completes. Later changes of `modeSel` do not alter the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initDone | input | 1 | High once the chip start-up sequence has finished |
| monPresent | input | 1 | Asynchronous downstream monitor-present level |
| modeSel | input | 1 | Policy select: 0 = pulse-notify, 1 = presence-gated |
| statClr | input | 1 | Host write-one-to-clear strobe for `statusChanged` |
| hpdLine | output | 1 | Hot-plug detect line level |
| sinkCount | output | SINK_W | Sink-count register value (0 or 1) |
| statusChanged | output | 1 | Sticky downstream status changed flag |

## Verification
The sticky flag can be set by an accepted monitor change and cleared by the host strobe in the same cycle. The bench counts the synchronizer and debounce registers to find the exact cycle in which a plug-in is accepted, and raises `statClr` for only that cycle. The flag must still read 1 afterwards. A second coincidence is a change that is accepted while a pulse or its quiet gap is running. The bench injects two changes during a pulse and measures the low, high and low run lengths on `hpdLine`. It expects 75, 200 and 75 cycles at the scaled clock setting, followed by no third pulse.

// File: rtl/hpd_sink_pkg.sv
package hpd_sink_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE_HI,
    ST_PULSE,
    ST_GAP,
    ST_GATED
  } hpdState_t;

  typedef struct packed {
    logic loadSink;
    logic setChg;
    logic loadPulse;
    logic loadGap;
  } ctrlStrobes_t;

endpackage

// File: rtl/hpd_sink_datapath.sv
module hpd_sink_datapath
  import hpd_sink_pkg::*;
#(
  parameter int CLK_FREQ_HZ   = 50_000_000,
  parameter int STABLE_CYCLES = 16,
  parameter int SINK_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              monAsync,
  input  logic              statClr,
  input  ctrlStrobes_t      strb,
  output logic              monStable,
  output logic              monChange,
  output logic              tmrZero,
  output logic [SINK_W-1:0] sinkCount,
  output logic              statusChanged
);

  localparam int IRQ_CYCLES = (CLK_FREQ_HZ * 3) / 4000;
  localparam int GAP_CYCLES = CLK_FREQ_HZ / 500;
  localparam int TMR_MAX    = (IRQ_CYCLES > GAP_CYCLES) ? IRQ_CYCLES : GAP_CYCLES;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int DB_W       = $clog2(STABLE_CYCLES + 1);

  logic syncA, syncB;
  logic [DB_W-1:0]  dbCnt;
  logic [TMR_W-1:0] tmr;

  // two-stage synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= monAsync;
      syncB <= syncA;
    end
  end

  // stability filter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbCnt     <= '0;
      monStable <= 1'b0;
      monChange <= 1'b0;
    end else begin
      monChange <= 1'b0;
      if (syncB == monStable) begin
        dbCnt <= '0;
      end else if (dbCnt == DB_W'(STABLE_CYCLES - 1)) begin
        dbCnt     <= '0;
        monStable <= syncB;
        monChange <= 1'b1;
      end else begin
        dbCnt <= dbCnt + DB_W'(1);
      end
    end
  end

  // shared pulse / gap down-counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strb.loadPulse) begin
      tmr <= TMR_W'(IRQ_CYCLES - 1);
    end else if (strb.loadGap) begin
      tmr <= TMR_W'(GAP_CYCLES - 1);
    end else if (tmr != '0) begin
      tmr <= tmr - TMR_W'(1);
    end
  end

  assign tmrZero = (tmr == '0);

  // sink count and sticky flag; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinkCount     <= '0;
      statusChanged <= 1'b0;
    end else begin
      if (strb.loadSink) sinkCount <= SINK_W'(monStable);
      if (strb.setChg) statusChanged <= 1'b1;
      else if (statClr) statusChanged <= 1'b0;
    end
  end

  p_glitch_filtered_r2: assert property (@(posedge clk) disable iff (!rstN)
    (syncB == monStable) |=> !monChange);

  p_sink_tracks_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSink |=> (sinkCount == SINK_W'($past(monStable))));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setChg |=> statusChanged);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusChanged && !statClr) |=> statusChanged);

endmodule

// File: rtl/hpd_sink_control.sv
module hpd_sink_control
  import hpd_sink_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         initDone,
  input  logic         modeSel,
  input  logic         monStable,
  input  logic         monChange,
  input  logic         tmrZero,
  output ctrlStrobes_t strb,
  output logic         hpdOut
);

  hpdState_t state, nextState;
  logic      pending;

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_INIT: begin
        if (initDone) begin
          strb.loadSink = 1'b1;
          nextState     = modeSel ? ST_GATED : ST_IDLE_HI;
        end
      end
      ST_IDLE_HI: begin
        if (monChange) begin
          strb.loadSink  = 1'b1;
          strb.setChg    = 1'b1;
          strb.loadPulse = 1'b1;
          nextState      = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (monChange) begin
          strb.loadSink = 1'b1;
          strb.setChg   = 1'b1;
        end
        if (tmrZero) begin
          strb.loadGap = 1'b1;
          nextState    = ST_GAP;
        end
      end
      ST_GAP: begin
        if (monChange) begin
          strb.loadSink = 1'b1;
          strb.setChg   = 1'b1;
        end
        if (tmrZero) begin
          if (pending || monChange) begin
            strb.loadPulse = 1'b1;
            nextState      = ST_PULSE;
          end else begin
            nextState = ST_IDLE_HI;
          end
        end
      end
      ST_GATED: begin
        if (monChange) strb.loadSink = 1'b1;
      end
      default: nextState = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_INIT;
      pending <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_GAP && tmrZero) pending <= 1'b0;
      else if (monChange && (state == ST_PULSE || state == ST_GAP)) pending <= 1'b1;
      else if (state != ST_PULSE && state != ST_GAP) pending <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      ST_IDLE_HI, ST_GAP: hpdOut = 1'b1;
      ST_GATED:           hpdOut = monStable;
      default:            hpdOut = 1'b0;
    endcase
  end

  p_hpd_low_init_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT) |-> !hpdOut);

  p_pulse_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && !tmrZero) |=> (state == ST_PULSE && !hpdOut));

  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && !tmrZero) |=> (state == ST_GAP && hpdOut));

  p_queue_issue_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && tmrZero && pending) |=> (state == ST_PULSE));

  p_gated_no_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GATED) |-> !strb.setChg);

  p_gated_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GATED) |=> (state == ST_GATED));

  p_pulse_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_INIT && state != ST_GATED) |=> (state != ST_GATED));

endmodule

// File: rtl/hpd_sink_ctrl.sv
module hpd_sink_ctrl
  import hpd_sink_pkg::*;
#(
  parameter int CLK_FREQ_HZ   = 50_000_000,
  parameter int STABLE_CYCLES = 16,
  parameter int SINK_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDone,
  input  logic              monPresent,
  input  logic              modeSel,
  input  logic              statClr,
  output logic              hpdLine,
  output logic [SINK_W-1:0] sinkCount,
  output logic              statusChanged
);

  ctrlStrobes_t strb;
  logic monStable, monChange, tmrZero;

  hpd_sink_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .initDone  (initDone),
    .modeSel   (modeSel),
    .monStable (monStable),
    .monChange (monChange),
    .tmrZero   (tmrZero),
    .strb      (strb),
    .hpdOut    (hpdLine)
  );

  hpd_sink_datapath #(
    .CLK_FREQ_HZ   (CLK_FREQ_HZ),
    .STABLE_CYCLES (STABLE_CYCLES),
    .SINK_W        (SINK_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .monAsync      (monPresent),
    .statClr       (statClr),
    .strb          (strb),
    .monStable     (monStable),
    .monChange     (monChange),
    .tmrZero       (tmrZero),
    .sinkCount     (sinkCount),
    .statusChanged (statusChanged)
  );

endmodule

// File: tb/hpd_sink_ctrl_tb.sv
module hpd_sink_ctrl_tb;

  localparam int CLK_HZ  = 100_000;  // scaled timing
  localparam int STABLE  = 8;
  localparam int EXP_IRQ = 75;       // 0.75 ms at CLK_HZ
  localparam int EXP_GAP = 200;      // 2 ms at CLK_HZ

  typedef struct packed {
    logic       mode;
    logic       mon;
    logic       expHpd;
    logic [7:0] expSink;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b0, 1'b1, 8'd0},
    '{1'b0, 1'b1, 1'b1, 8'd1},
    '{1'b1, 1'b0, 1'b0, 8'd0},
    '{1'b1, 1'b1, 1'b1, 8'd1}
  };

  logic clk = 1'b0;
  logic rstN, initDone, monPresent, modeSel, statClr;
  logic hpdLine, statusChanged;
  logic [7:0] sinkCount;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  hpd_sink_ctrl #(
    .CLK_FREQ_HZ   (CLK_HZ),
    .STABLE_CYCLES (STABLE),
    .SINK_W        (8)
  ) u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .initDone      (initDone),
    .monPresent    (monPresent),
    .modeSel       (modeSel),
    .statClr       (statClr),
    .hpdLine       (hpdLine),
    .sinkCount     (sinkCount),
    .statusChanged (statusChanged)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  task automatic applyReset(input logic mode, input logic mon);
    @(negedge clk);
    rstN = 1'b0; initDone = 1'b0; statClr = 1'b0;
    modeSel = mode; monPresent = mon;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (STABLE + 6) @(negedge clk);
  endtask

  task automatic startUp();
    initDone = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic countLevel(input logic lvl, output int n);
    n = 0;
    while (hpdLine == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    endRun();
  end

  initial begin
    int lowA, highB, lowC, lows;
    rstN = 1'b0; initDone = 1'b0; monPresent = 1'b0; modeSel = 1'b0; statClr = 1'b0;

    // table: start-up behaviour per policy and monitor state
    for (int i = 0; i < 4; i++) begin
      applyReset(VECS[i].mode, VECS[i].mon);
      checkEq("R1", "hpd before init", int'(hpdLine), 0);
      checkEq("R1", "sink before init", int'(sinkCount), 0);
      checkEq("R1", "flag before init", int'(statusChanged), 0);
      startUp();
      checkEq(VECS[i].mode ? "R8" : "R4", "hpd after init", int'(hpdLine), int'(VECS[i].expHpd));
      checkEq("R3", "sink after init", int'(sinkCount), int'(VECS[i].expSink));
      checkEq("R5", "flag after init", int'(statusChanged), 0);
    end

    // pulse policy: plug-in coinciding with host clear (R5), pulse width (R6)
    applyReset(1'b0, 1'b0);
    startUp();
    @(negedge clk);
    monPresent = 1'b1;
    repeat (STABLE + 2) @(posedge clk);
    @(negedge clk);
    statClr = 1'b1;                 // same cycle as the set
    @(negedge clk);
    statClr = 1'b0;
    checkEq("R5", "flag after set+clear", int'(statusChanged), 1);
    checkEq("R3", "sink after plug", int'(sinkCount), 1);
    checkEq("R6", "hpd low at event", int'(hpdLine), 0);
    countLevel(1'b0, lowA);
    checkEq("R6", "pulse width", lowA, EXP_IRQ);
    checkEq("R6", "hpd back high", int'(hpdLine), 1);
    repeat (EXP_GAP + 10) @(negedge clk);
    statClr = 1'b1;
    @(negedge clk);
    statClr = 1'b0;
    checkEq("R5", "flag after clear", int'(statusChanged), 0);

    // short glitch is ignored (R2)
    monPresent = 1'b0;
    repeat (STABLE - 3) @(negedge clk);
    monPresent = 1'b1;
    lows = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!hpdLine) lows++;
    end
    checkEq("R2", "lows after glitch", lows, 0);
    checkEq("R2", "sink after glitch", int'(sinkCount), 1);
    checkEq("R2", "flag after glitch", int'(statusChanged), 0);

    // queued changes (R7), mode pin change ignored (R9)
    modeSel = 1'b1;
    monPresent = 1'b0;
    lows = 0;
    while (hpdLine && lows < 100) begin
      lows++;
      @(negedge clk);
    end
    fork
      begin
        countLevel(1'b0, lowA);
        countLevel(1'b1, highB);
        countLevel(1'b0, lowC);
      end
      begin
        monPresent = 1'b1;
        repeat (20) @(negedge clk);
        monPresent = 1'b0;
      end
    join
    checkEq("R9", "first pulse width after pin change", lowA, EXP_IRQ);
    checkEq("R7", "gap before queued pulse", highB, EXP_GAP);
    checkEq("R7", "queued pulse width", lowC, EXP_IRQ);
    lows = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!hpdLine) lows++;
    end
    checkEq("R7", "extra pulses after collapse", lows, 0);
    checkEq("R3", "sink after queued changes", int'(sinkCount), 0);
    checkEq("R5", "flag after queued changes", int'(statusChanged), 1);

    // gated policy (R8), pin change ignored (R9)
    applyReset(1'b1, 1'b0);
    startUp();
    checkEq("R8", "hpd gated no monitor", int'(hpdLine), 0);
    monPresent = 1'b1;
    repeat (STABLE + 6) @(negedge clk);
    checkEq("R8", "hpd gated monitor on", int'(hpdLine), 1);
    checkEq("R3", "sink gated plug", int'(sinkCount), 1);
    modeSel = 1'b0;
    monPresent = 1'b0;
    repeat (STABLE + 6) @(negedge clk);
    checkEq("R8", "hpd gated monitor off", int'(hpdLine), 0);
    checkEq("R3", "sink gated unplug", int'(sinkCount), 0);
    monPresent = 1'b1;
    lows = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (k > STABLE + 6 && !hpdLine) lows++;
    end
    checkEq("R9", "no pulse after pin change", lows, 0);
    checkEq("R8", "flag never set gated", int'(statusChanged), 0);

    endRun();
  end

endmodule